// File: doc/BRIEF.md
# Ethernet Transmit Error Statistics Unit

This block sits beside the transmit engine of a half-duplex Ethernet MAC and keeps management counters for transmit failures. The engine reports each frame through single-cycle event strobes (start, in-window collision, out-of-window collision, underrun, manual abort, end) and two levels (carrier sense, deferring). The block tracks the open frame, counts its in-window collisions, and times the cycles spent deferring to the medium. When either limit is passed it raises an abort towards the engine. When the frame closes it decides the outcome and bumps each matching counter once.

After a frame that completes normally, the block opens a short window for the collision heartbeat (SQE test) pulse from the physical layer. If the heartbeat is missing and checking was enabled when the frame ended, it records the miss. Software reads the six saturating counters through a simple read port. A read returns the value and clears the counter in the same step, and no event that lands in the read cycle is lost.

Top module: `txerr_stats`

## Requirements
- R1: On the 16th (`MAX_COLL`) in-window collision of a frame, `tx_abort_o` is high in that same cycle and the frame closes. The excess-collision counter (address 1) and the errored counter each increment by one.
- R2: Deferring cycles are counted from start of frame and accumulate across the frame. The limit is `DEFER_CYC = CLK_HZ/1e6*DEFER_US`. If `tx_defer` is high in a cycle where `DEFER_CYC` deferring cycles have already been counted, `tx_abort_o` is high in that cycle, the frame closes, and the excess-deferral counter (address 2) and the errored counter increment. A frame that defers for exactly `DEFER_CYC` cycles is not aborted.
- R3: A late collision strobe inside a frame closes it and increments the out-of-window counter (address 3) and the errored counter.
- R4: The carrier counter (address 4) increments once for a frame if `tx_crs` is low in any cycle where the frame is open and not deferring. The count is made when the frame closes, whatever the cause of the close.
- R5: After a frame ends with `tx_eof` and no abort, and `hb_chk_en` was high in the end cycle, a `tx_heartbeat` pulse is expected in cycles 1 to `HB_WIN` after the end. If none arrives, the SQE counter (address 5) increments. With `hb_chk_en` low at the end, no SQE error is recorded.
- R6: The errored counter (address 0) increments for every aborted frame, including underrun and manual aborts. A frame that ends with `tx_eof` after fewer than 16 collisions is not counted in it.
- R7: Each counter moves by at most one per frame. Strobes outside an open frame are ignored, as are strobes in the start cycle and strobes after the frame has closed.
- R8: Counters saturate at all ones and do not wrap.
- R9: With `rd_en` high, `rd_data` shows the addressed counter on the next cycle and that counter is cleared. An increment arriving in the read cycle leaves the counter at 1. Addresses 6 and 7 read as 0.
- R10: After reset all counters and `rd_data` are 0 and `tx_abort_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_chk_en | input | 1 | Enable for heartbeat checking, sampled at frame end |
| tx_sof | input | 1 | Start-of-frame strobe |
| tx_coll | input | 1 | In-window collision strobe |
| tx_late_coll | input | 1 | Out-of-window collision strobe |
| tx_crs | input | 1 | Carrier sense level |
| tx_defer | input | 1 | High while waiting for the medium |
| tx_underrun | input | 1 | FIFO underrun abort strobe |
| tx_man_abort | input | 1 | Manual abort strobe |
| tx_heartbeat | input | 1 | Collision heartbeat pulse from the physical layer |
| tx_eof | input | 1 | Normal end-of-frame strobe |
| rd_en | input | 1 | Counter read (and clear) request |
| rd_addr | input | 3 | Counter address 0..5 |
| rd_data | output | CNT_W | Counter value, valid the cycle after rd_en |
| tx_abort_o | output | 1 | Abort request on excess collisions or deferral |

## Verification
The bench targets the limits on both sides. It drives 15 and 16 collisions, deferral of exactly `DEFER_CYC` and `DEFER_CYC+1` cycles, and heartbeats in the last cycle of the window and one cycle after it. An off-by-one in any of these would move a frame between success and abort, or between pass and SQE error. It places a counted event in the same cycle as a read of that counter: a design that gave priority to the clear would return 0 on the next read instead of 1. Stray strobes outside a frame would inflate counters in a design that did not gate on the open frame. A long run of aborts on a narrow counter would show a wrap to 0 if saturation were missing.

// File: rtl/txerr_pkg.sv
package txerr_pkg;

    localparam int NCNT   = 6;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ERRORED = 3'd0,
        SEL_XCOLL   = 3'd1,
        SEL_XDEFER  = 3'd2,
        SEL_LATE    = 3'd3,
        SEL_CARRIER = 3'd4,
        SEL_SQE     = 3'd5
    } cnt_sel_e;

    // outcome of a frame, valid in the cycle it closes
    typedef struct packed {
        logic errored;
        logic xcoll;
        logic xdefer;
        logic late;
        logic carrier;
        logic done_ok;
    } close_flags_t;

    function automatic longint defer_cycles(input longint clk_hz, input longint usec);
        return (clk_hz * usec) / 64'd1000000;
    endfunction

endpackage

// File: rtl/txerr_frame.sv
module txerr_frame
    import txerr_pkg::*;
#(
    parameter int MAX_COLL  = 16,
    parameter int DEFER_CYC = 160000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sof,
    input  logic         coll,
    input  logic         late_coll,
    input  logic         crs,
    input  logic         defer,
    input  logic         underrun,
    input  logic         man_abort,
    input  logic         eof,
    output logic         close_o,
    output close_flags_t flags_o,
    output logic         limit_abort_o
);

    localparam int CW = $clog2(MAX_COLL + 1);
    localparam int DW = $clog2(DEFER_CYC + 1);

    logic          open_q;
    logic [CW-1:0] coll_q;
    logic [DW-1:0] dtmr_q;
    logic          crs_bad_q;

    logic active, coll_hit, defer_hit, crs_now, abort_any;

    always_comb begin
        active    = open_q && !sof;
        coll_hit  = active && coll && (coll_q == CW'(MAX_COLL - 1));
        defer_hit = active && defer && (dtmr_q == DW'(DEFER_CYC));
        crs_now   = active && !defer && !crs;
        abort_any = coll_hit || defer_hit || (active && (late_coll || underrun || man_abort));
        close_o   = abort_any || (active && eof);

        flags_o.errored = abort_any;
        flags_o.xcoll   = coll_hit;
        flags_o.xdefer  = defer_hit;
        flags_o.late    = active && late_coll;
        flags_o.carrier = close_o && (crs_bad_q || crs_now);
        flags_o.done_ok = active && eof && !abort_any;

        limit_abort_o = coll_hit || defer_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            coll_q    <= '0;
            dtmr_q    <= '0;
            crs_bad_q <= 1'b0;
        end else if (sof) begin
            open_q    <= 1'b1;
            coll_q    <= '0;
            dtmr_q    <= '0;
            crs_bad_q <= 1'b0;
        end else if (open_q) begin
            if (close_o) begin
                open_q <= 1'b0;
            end else begin
                coll_q    <= coll_q + CW'(coll);
                dtmr_q    <= dtmr_q + DW'(defer);
                crs_bad_q <= crs_bad_q || crs_now;
            end
        end
    end

endmodule

// File: rtl/txerr_hb.sv
module txerr_hb #(
    parameter int HB_WIN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic heartbeat,
    output logic miss_o
);

    localparam int HW = $clog2(HB_WIN + 1);

    logic [HW-1:0] win_q;

    assign miss_o = (win_q == HW'(1)) && !heartbeat;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (arm) begin
            win_q <= HW'(HB_WIN);
        end else if (win_q != '0) begin
            if (heartbeat || win_q == HW'(1)) begin
                win_q <= '0;
            end else begin
                win_q <= win_q - HW'(1);
            end
        end
    end

endmodule

// File: rtl/txerr_bank.sv
module txerr_bank
    import txerr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCNT-1:0]            inc,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [CNT_W-1:0]           rd_data,
    output logic [NCNT-1:0][CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] sel;

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        logic hit;
        assign hit = rd_en && (rd_addr == ADDR_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_o[i] <= '0;
            end else if (hit) begin
                cnt_o[i] <= CNT_W'(inc[i]);
            end else if (inc[i] && !(&cnt_o[i])) begin
                cnt_o[i] <= cnt_o[i] + CNT_W'(1);
            end
        end
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (rd_addr == ADDR_W'(i)) sel = cnt_o[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

endmodule

// File: rtl/txerr_stats.sv
module txerr_stats
    import txerr_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int DEFER_US = 3200,
    parameter int MAX_COLL = 16,
    parameter int HB_WIN   = 16,
    parameter int CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hb_chk_en,
    input  logic             tx_sof,
    input  logic             tx_coll,
    input  logic             tx_late_coll,
    input  logic             tx_crs,
    input  logic             tx_defer,
    input  logic             tx_underrun,
    input  logic             tx_man_abort,
    input  logic             tx_heartbeat,
    input  logic             tx_eof,
    input  logic             rd_en,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             tx_abort_o
);

    localparam int DEFER_CYC = int'(defer_cycles(longint'(CLK_HZ), longint'(DEFER_US)));

    logic                       closing;
    close_flags_t               flags;
    logic                       sqe_miss;
    logic [NCNT-1:0]            inc;
    logic [NCNT-1:0][CNT_W-1:0] cnt_flat;

    txerr_frame #(.MAX_COLL(MAX_COLL), .DEFER_CYC(DEFER_CYC)) u_frame (
        .clk(clk), .rst(rst), .sof(tx_sof), .coll(tx_coll), .late_coll(tx_late_coll),
        .crs(tx_crs), .defer(tx_defer), .underrun(tx_underrun), .man_abort(tx_man_abort),
        .eof(tx_eof), .close_o(closing), .flags_o(flags), .limit_abort_o(tx_abort_o)
    );

    txerr_hb #(.HB_WIN(HB_WIN)) u_hb (
        .clk(clk), .rst(rst), .arm(flags.done_ok && hb_chk_en),
        .heartbeat(tx_heartbeat), .miss_o(sqe_miss)
    );

    always_comb begin
        inc              = '0;
        inc[SEL_ERRORED] = closing && flags.errored;
        inc[SEL_XCOLL]   = closing && flags.xcoll;
        inc[SEL_XDEFER]  = closing && flags.xdefer;
        inc[SEL_LATE]    = closing && flags.late;
        inc[SEL_CARRIER] = closing && flags.carrier;
        inc[SEL_SQE]     = sqe_miss;
    end

    txerr_bank #(.CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst(rst), .inc(inc), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .cnt_o(cnt_flat)
    );

endmodule

// File: rtl/txerr_stats_chk.sv
module txerr_stats_chk
    import txerr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       rd_en,
    input logic [2:0]                 rd_addr,
    input logic [CNT_W-1:0]           rd_data,
    input logic                       tx_abort_o,
    input logic [NCNT-1:0][CNT_W-1:0] cnt_flat
);

    // R1 / R2: an abort closes the frame, so it never lasts two cycles
    assert_abort_single_R1: assert property (@(posedge clk) disable iff (rst)
        tx_abort_o |=> !tx_abort_o);

    // R9: unmapped addresses read as zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr >= 3'(NCNT)) |=> (rd_data == '0));

    // R9: read data holds between reads
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R10: reset clears the read data
    assert_reset_rdata_R10: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    for (genvar i = 0; i < NCNT; i++) begin : g_chk
        // R7: without a read a counter stays or steps by one
        assert_step_one_R7: assert property (@(posedge clk) disable iff (rst)
            !(rd_en && rd_addr == 3'(i)) |=>
            (cnt_flat[i] == $past(cnt_flat[i]) || cnt_flat[i] == $past(cnt_flat[i]) + CNT_W'(1)));
        // R8: saturated counters stay saturated until read
        assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
            (!(rd_en && rd_addr == 3'(i)) && (&cnt_flat[i])) |=> (&cnt_flat[i]));
        // R9: a read leaves at most the same-cycle increment
        assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (rst)
            (rd_en && rd_addr == 3'(i)) |=> (cnt_flat[i] <= CNT_W'(1)));
    end

endmodule

bind txerr_stats txerr_stats_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_abort_o(tx_abort_o), .cnt_flat(cnt_flat)
);

// File: tb/sim_txerr_stats.sv
module sim_txerr_stats;

    localparam int B_CLK_HZ   = 50_000_000;
    localparam int B_DEFER_US = 2;
    localparam int B_DEFER    = B_CLK_HZ / 1_000_000 * B_DEFER_US;   // 100 cycles
    localparam int B_COLL     = 16;
    localparam int B_HBWIN    = 8;
    localparam int B_W        = 8;                                    // narrow to reach saturation
    localparam longint MAXV   = (64'd1 << B_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hb_chk_en = 1'b0, tx_sof = 1'b0, tx_coll = 1'b0, tx_late_coll = 1'b0;
    logic tx_crs = 1'b0, tx_defer = 1'b0, tx_underrun = 1'b0, tx_man_abort = 1'b0;
    logic tx_heartbeat = 1'b0, tx_eof = 1'b0, rd_en = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [B_W-1:0] rd_data;
    logic tx_abort_o;

    int n_chk = 0;
    int n_fail = 0;
    longint exp_c [6];

    always #10 clk = ~clk;

    txerr_stats #(.CLK_HZ(B_CLK_HZ), .DEFER_US(B_DEFER_US), .MAX_COLL(B_COLL),
                  .HB_WIN(B_HBWIN), .CNT_W(B_W)) u0 (
        .clk(clk), .rst(rst), .hb_chk_en(hb_chk_en), .tx_sof(tx_sof), .tx_coll(tx_coll),
        .tx_late_coll(tx_late_coll), .tx_crs(tx_crs), .tx_defer(tx_defer),
        .tx_underrun(tx_underrun), .tx_man_abort(tx_man_abort), .tx_heartbeat(tx_heartbeat),
        .tx_eof(tx_eof), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_abort_o(tx_abort_o)
    );

    function automatic string tag(input int idx);
        case (idx)
            0: return "R6";
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            default: return "R9";
        endcase
    endfunction

    function automatic longint bump(input longint v);
        return (v < MAXV) ? v + 1 : v;
    endfunction

    task automatic chk(input string req, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    task automatic read_cnt(input int idx);
        rd_en = 1'b1; rd_addr = 3'(idx);
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag(idx), " read/clear R9"}, longint'(rd_data), (idx < 6) ? exp_c[idx] : 0);
        if (idx < 6) exp_c[idx] = 0;
    endtask

    task automatic read_all();
        for (int i = 0; i < 8; i++) read_cnt(i);
    endtask

    // kind: 0 eof, 1 late collision, 2 underrun, 3 manual abort; hb_d: 0 none, else delay after eof
    task automatic run_frame(input int defer_n, input int ncoll, input int kind,
                             input bit crs_drop, input int hb_d, input bit hb_en);
        bit ab = 1'b0;
        hb_chk_en = hb_en;
        tx_sof = 1'b1; @(negedge clk); tx_sof = 1'b0;
        for (int k = 0; k < defer_n; k++) begin
            tx_defer = 1'b1; tx_crs = 1'b0;
            #1;
            chk("R2 abort at deferral limit", longint'(tx_abort_o), (k == B_DEFER) ? 1 : 0);
            @(negedge clk);
            if (k == B_DEFER) begin ab = 1'b1; break; end
        end
        tx_defer = 1'b0;
        if (!ab) begin
            tx_crs = 1'b1;
            if (crs_drop) begin tx_crs = 1'b0; @(negedge clk); tx_crs = 1'b1; end
            for (int k = 0; k < ncoll; k++) begin
                tx_coll = 1'b1;
                #1;
                if (k >= B_COLL - 2)
                    chk("R1 abort on 16th collision", longint'(tx_abort_o), (k == B_COLL - 1) ? 1 : 0);
                @(negedge clk);
                tx_coll = 1'b0;
                if (k == B_COLL - 1) begin ab = 1'b1; break; end
                @(negedge clk);
            end
        end
        if (!ab) begin
            case (kind)
                0: tx_eof = 1'b1;
                1: tx_late_coll = 1'b1;
                2: tx_underrun = 1'b1;
                default: tx_man_abort = 1'b1;
            endcase
            @(negedge clk);
            tx_eof = 1'b0; tx_late_coll = 1'b0; tx_underrun = 1'b0; tx_man_abort = 1'b0;
        end
        tx_crs = 1'b0;
        if (!ab && kind == 0 && hb_d > 0) begin
            repeat (hb_d - 1) @(negedge clk);
            tx_heartbeat = 1'b1; @(negedge clk); tx_heartbeat = 1'b0;
        end
        repeat (B_HBWIN + 2) @(negedge clk);
        // expected outcome from the requirements
        if (defer_n > B_DEFER) begin
            exp_c[0] = bump(exp_c[0]); exp_c[2] = bump(exp_c[2]);
        end else begin
            if (crs_drop) exp_c[4] = bump(exp_c[4]);
            if (ncoll >= B_COLL) begin
                exp_c[0] = bump(exp_c[0]); exp_c[1] = bump(exp_c[1]);
            end else if (kind == 1) begin
                exp_c[0] = bump(exp_c[0]); exp_c[3] = bump(exp_c[3]);
            end else if (kind != 0) begin
                exp_c[0] = bump(exp_c[0]);
            end else if (hb_en && (hb_d == 0 || hb_d > B_HBWIN)) begin
                exp_c[5] = bump(exp_c[5]);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd7177);
        for (int i = 0; i < 6; i++) exp_c[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 rd_data after reset", longint'(rd_data), 0);
        chk("R10 abort low after reset", longint'(tx_abort_o), 0);
        read_all();

        // directed boundaries
        run_frame(0, B_COLL - 1, 0, 1'b0, 1, 1'b1);        // R6: 15 collisions then success
        run_frame(0, B_COLL, 0, 1'b0, 0, 1'b1);            // R1: 16 collisions abort
        run_frame(B_DEFER, 0, 0, 1'b0, B_HBWIN, 1'b1);     // R2: exactly at limit, no abort; R5 last window cycle
        run_frame(B_DEFER + 1, 0, 0, 1'b0, 0, 1'b1);       // R2: one past limit
        run_frame(0, 0, 0, 1'b0, B_HBWIN + 1, 1'b1);       // R5: heartbeat too late
        run_frame(0, 0, 0, 1'b0, 0, 1'b0);                 // R5: checking disabled
        run_frame(0, 2, 1, 1'b1, 0, 1'b1);                 // R3 + R4 together
        run_frame(0, 0, 2, 1'b0, 0, 1'b1);                 // R6 underrun
        run_frame(0, 0, 3, 1'b1, 0, 1'b1);                 // R6 manual, R4
        read_all();

        // R7: strobes with no open frame and after a close are ignored
        tx_late_coll = 1'b1; tx_underrun = 1'b1; tx_man_abort = 1'b1; tx_eof = 1'b1; tx_coll = 1'b1;
        @(negedge clk);
        tx_late_coll = 1'b0; tx_underrun = 1'b0; tx_man_abort = 1'b0; tx_eof = 1'b0; tx_coll = 1'b0;
        tx_sof = 1'b1; tx_late_coll = 1'b1; @(negedge clk); tx_sof = 1'b0;     // strobe in start cycle ignored
        tx_crs = 1'b1; tx_late_coll = 1'b1; tx_underrun = 1'b1; @(negedge clk); // closes once
        tx_late_coll = 1'b1; tx_man_abort = 1'b1; @(negedge clk);             // after close: ignored
        tx_late_coll = 1'b0; tx_underrun = 1'b0; tx_man_abort = 1'b0; tx_crs = 1'b0;
        repeat (B_HBWIN + 2) @(negedge clk);
        exp_c[0] = bump(exp_c[0]); exp_c[3] = bump(exp_c[3]);
        for (int i = 0; i < 6; i++) begin
            rd_en = 1'b1; rd_addr = 3'(i); @(negedge clk); rd_en = 1'b0;
            chk("R7 one count per frame", longint'(rd_data), exp_c[i]);
            exp_c[i] = 0;
        end

        // R9: increment in the same cycle as a read of that counter
        run_frame(0, 0, 3, 1'b0, 0, 1'b1);
        tx_sof = 1'b1; @(negedge clk); tx_sof = 1'b0;
        tx_crs = 1'b1; tx_man_abort = 1'b1; rd_en = 1'b1; rd_addr = 3'd0;
        @(negedge clk);
        tx_man_abort = 1'b0; rd_en = 1'b0; tx_crs = 1'b0;
        chk("R9 read returns old value", longint'(rd_data), exp_c[0]);
        exp_c[0] = 1;
        read_cnt(0);
        chk("R9 read returns old value", longint'(rd_data), 1);

        // random frames
        for (int f = 0; f < 60; f++) begin
            int r, dn, nc;
            r  = $urandom % 8;
            dn = (r == 0) ? B_DEFER + 1 : (r == 1) ? B_DEFER : $urandom % 5;
            r  = $urandom % 6;
            nc = (r == 0) ? B_COLL : (r == 1) ? B_COLL - 1 : $urandom % 4;
            run_frame(dn, nc, $urandom % 4, ($urandom % 4) == 0,
                      $urandom % (B_HBWIN + 2), ($urandom % 4) != 0);
            if (f % 5 == 4) read_all();
        end
        read_all();

        // R8: saturation of the errored counter
        for (int f = 0; f < 270; f++) begin
            tx_sof = 1'b1; @(negedge clk); tx_sof = 1'b0;
            tx_crs = 1'b1; tx_man_abort = 1'b1; @(negedge clk);
            tx_man_abort = 1'b0; tx_crs = 1'b0;
            exp_c[0] = bump(exp_c[0]);
        end
        @(negedge clk);
        chk("R8 model at all ones", exp_c[0], MAXV);
        read_cnt(0);
        read_cnt(0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule